// File: doc/BRIEF.md
# Sliding-Window Rank Sorter

This block keeps a reference window of the sixteen most recent 8-bit unsigned samples in ascending sorted order as a sample stream passes through. The window lives only in flip-flops. Each accepted sample displaces the oldest one in a single clock, so the window never needs a full re-sort.

Every stored slot carries an age tag. On a valid input, the slot holding the oldest sample is dropped and the slots above it close the gap. The new sample is then placed after every entry that is less than or equal to it, and the entries above that point move up one place. This makes a sample that ties with stored values land behind them, so ties keep their arrival order.

The block publishes the whole sorted vector. It also publishes, from a register, the twelfth-smallest value, which is the three-quarter point of the window and serves as the order statistic for a threshold stage further down. A flag reports once sixteen samples have entered since reset. The caller supplies the value that is leaving the window alongside the new sample. That value is the sample accepted sixteen valid strobes earlier, or zero while the window is still filling.

Top module: `sw_rank_sorter`

## Requirements
- R1: After synchronous reset, every sorted slot reads zero, `rank_out` is zero and `window_full` is low.
- R2: `sorted_out` is always nondecreasing from slot 0 (smallest) to slot 15 (largest).
- R3: On the clock edge that samples `in_valid` high, the window drops its oldest sample and inserts `in_sample`. After that edge, `sorted_out` holds the ascending sort of the 16 most recent accepted samples, with zeros standing in for samples not yet received after reset.
- R4: `rank_out` is the value of sorted slot 11 (the 12th smallest), registered. It shows the window state one clock after `sorted_out` shows that state, so it is due two edges after the valid input.
- R5: A cycle with `in_valid` low leaves `sorted_out` unchanged.
- R6: `window_full` rises on the edge that accepts the 16th valid sample after reset and stays high until reset.
- R7: When `in_valid` is high, `evict_sample` equals the value of the slot being dropped: the sample accepted 16 valid strobes earlier, or zero during the fill phase.
- R8: Sorted slot k occupies bits [8k+7:8k] of `sorted_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | New sample strobe |
| in_sample | input | 8 | Sample entering the window |
| evict_sample | input | 8 | Sample leaving the window |
| sorted_out | output | 128 | Sorted window, slot 0 in the low byte |
| rank_out | output | 8 | Registered 12th-smallest value |
| window_full | output | 1 | High once 16 samples have entered |

## Verification
The sorted vector and the fill flag change on the same edge that accepts the sample. The bench therefore drives on the falling edge, waits one rising edge, and compares both at the next falling edge against a sorted copy of its own sixteen-deep arrival queue. The rank output comes one register later. For that reason, each cycle's rank check uses the expected rank the bench computed at the previous falling edge, and the bench refreshes that value only after the check, idle cycles included. The stimulus covers ramps in both directions, constant and alternating extremes, heavy ties drawn from a narrow range, and full-range values with idle gaps.

// File: rtl/sw_sort_pkg.sv
package sw_sort_pkg;

    // Default geometry of the sorted reference window.
    localparam int SW_DATA_W = 8;
    localparam int SW_DEPTH  = 16;
    localparam int SW_RANK   = 12;

    // Width needed to tag each slot with its age (0 = newest).
    function automatic int age_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    // Width of a counter that must reach `depth` itself.
    function automatic int count_bits(input int depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/sw_oldest_find.sv
module sw_oldest_find #(
    parameter int DEPTH = 16,
    parameter int AGE_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AGE_W-1:0] ages   [DEPTH],
    output logic [DEPTH-1:0] hit,
    output logic [DEPTH-1:0] close_mask
);
    localparam logic [AGE_W-1:0] OLDEST = AGE_W'(DEPTH - 1);

    // One-hot marker of the slot whose age tag is the oldest.
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_hit
            assign hit[i] = (ages[i] == OLDEST);
        end
    endgenerate

    // Prefix OR: slot i and every slot above the dropped one take from i+1.
    always_comb begin
        close_mask[0] = hit[0];
        for (int i = 1; i < DEPTH; i++) begin
            close_mask[i] = close_mask[i-1] | hit[i];
        end
    end

    // R3: the age tags form a permutation, so exactly one slot is oldest.
    p_one_oldest_r3: assert property (@(posedge clk) disable iff (rst)
        $countones(hit) == 1);

endmodule

// File: rtl/sw_compact.sv
module sw_compact #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int AGE_W  = 4
) (
    input  logic [DATA_W-1:0] vals       [DEPTH],
    input  logic [AGE_W-1:0]  ages       [DEPTH],
    input  logic [DEPTH-1:0]  hit,
    input  logic [DEPTH-1:0]  close_mask,
    output logic [DATA_W-1:0] cvals      [DEPTH-1],
    output logic [AGE_W-1:0]  cages      [DEPTH-1],
    output logic [DATA_W-1:0] dropped
);
    // Close the gap left by the dropped slot. Surviving slots age by one.
    generate
        for (genvar i = 0; i < DEPTH - 1; i++) begin : g_close
            assign cvals[i] = close_mask[i] ? vals[i+1] : vals[i];
            assign cages[i] = (close_mask[i] ? ages[i+1] : ages[i]) + AGE_W'(1);
        end
    endgenerate

    // Value leaving the window, taken from the one-hot position.
    always_comb begin
        dropped = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit[i]) begin
                dropped = vals[i];
            end
        end
    end

endmodule

// File: rtl/sw_insert.sv
module sw_insert #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int AGE_W  = 4
) (
    input  logic [DATA_W-1:0] cvals [DEPTH-1],
    input  logic [AGE_W-1:0]  cages [DEPTH-1],
    input  logic [DATA_W-1:0] sample,
    output logic [DATA_W-1:0] nvals [DEPTH],
    output logic [AGE_W-1:0]  nages [DEPTH]
);
    // stay[i]: compacted slot i sorts at or before the new sample.
    // Using <= puts a tie behind the equal stored entries.
    // The top slot never stays, so the sample always finds a place.
    logic [DEPTH-1:0] stay;

    generate
        for (genvar i = 0; i < DEPTH - 1; i++) begin : g_cmp
            assign stay[i] = (cvals[i] <= sample);
        end
        assign stay[DEPTH-1] = 1'b0;

        // Slot 0: keep, else take the sample.
        assign nvals[0] = stay[0] ? cvals[0] : sample;
        assign nages[0] = stay[0] ? cages[0] : '0;

        // Slots 1 .. DEPTH-2: keep, take the sample at the boundary, or shift up.
        for (genvar i = 1; i < DEPTH - 1; i++) begin : g_mid
            always_comb begin
                if (stay[i]) begin
                    nvals[i] = cvals[i];
                    nages[i] = cages[i];
                end else if (stay[i-1]) begin
                    nvals[i] = sample;
                    nages[i] = '0;
                end else begin
                    nvals[i] = cvals[i-1];
                    nages[i] = cages[i-1];
                end
            end
        end

        // Top slot: sample if everything below stays, else shift up.
        assign nvals[DEPTH-1] = stay[DEPTH-2] ? sample : cvals[DEPTH-2];
        assign nages[DEPTH-1] = stay[DEPTH-2] ? '0     : cages[DEPTH-2];
    endgenerate

endmodule

// File: rtl/sw_rank_sorter.sv
module sw_rank_sorter
    import sw_sort_pkg::*;
#(
    parameter int DATA_W = SW_DATA_W,
    parameter int DEPTH  = SW_DEPTH,
    parameter int RANK   = SW_RANK
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [DATA_W-1:0]       in_sample,
    input  logic [DATA_W-1:0]       evict_sample,
    output logic [DEPTH*DATA_W-1:0] sorted_out,
    output logic [DATA_W-1:0]       rank_out,
    output logic                    window_full
);
    localparam int AGE_W = age_bits(DEPTH);
    localparam int CNT_W = count_bits(DEPTH);

    logic [DATA_W-1:0] val_q  [DEPTH];
    logic [AGE_W-1:0]  age_q  [DEPTH];
    logic [DATA_W-1:0] cvals  [DEPTH-1];
    logic [AGE_W-1:0]  cages  [DEPTH-1];
    logic [DATA_W-1:0] nvals  [DEPTH];
    logic [AGE_W-1:0]  nages  [DEPTH];
    logic [DEPTH-1:0]  hit;
    logic [DEPTH-1:0]  close_mask;
    logic [DATA_W-1:0] dropped;
    logic [CNT_W-1:0]  fill_cnt;
    logic              full_q;
    logic [DATA_W-1:0] rank_q;

    sw_oldest_find #(.DEPTH(DEPTH), .AGE_W(AGE_W)) u_find (
        .clk        (clk),
        .rst        (rst),
        .ages       (age_q),
        .hit        (hit),
        .close_mask (close_mask)
    );

    sw_compact #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AGE_W(AGE_W)) u_compact (
        .vals       (val_q),
        .ages       (age_q),
        .hit        (hit),
        .close_mask (close_mask),
        .cvals      (cvals),
        .cages      (cages),
        .dropped    (dropped)
    );

    sw_insert #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AGE_W(AGE_W)) u_insert (
        .cvals  (cvals),
        .cages  (cages),
        .sample (in_sample),
        .nvals  (nvals),
        .nages  (nages)
    );

    // Sorted register file. On reset, slots hold zero and ages 0..DEPTH-1,
    // so the zero placeholders leave in a fixed order during fill.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                val_q[i] <= '0;
                age_q[i] <= AGE_W'(i);
            end
        end else if (in_valid) begin
            for (int i = 0; i < DEPTH; i++) begin
                val_q[i] <= nvals[i];
                age_q[i] <= nages[i];
            end
        end
    end

    // Order-statistic tap, one register behind the window.
    always_ff @(posedge clk) begin
        if (rst) begin
            rank_q <= '0;
        end else begin
            rank_q <= val_q[RANK-1];
        end
    end

    // Fill tracking.
    always_ff @(posedge clk) begin
        if (rst) begin
            fill_cnt <= '0;
            full_q   <= 1'b0;
        end else if (in_valid && fill_cnt != CNT_W'(DEPTH)) begin
            fill_cnt <= fill_cnt + CNT_W'(1);
            full_q   <= full_q | (fill_cnt == CNT_W'(DEPTH - 1));
        end
    end

    generate
        for (genvar k = 0; k < DEPTH; k++) begin : g_pack
            assign sorted_out[k*DATA_W +: DATA_W] = val_q[k];
        end
    endgenerate

    assign rank_out    = rank_q;
    assign window_full = full_q;

    // R2: neighbouring slots stay in ascending order.
    generate
        for (genvar k = 0; k < DEPTH - 1; k++) begin : g_order_chk
            p_ascending_r2: assert property (@(posedge clk) disable iff (rst)
                val_q[k] <= val_q[k+1]);
        end
    endgenerate

    // R5: no strobe, no change to the window.
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(sorted_out));

    // R6: the fill flag never drops once set.
    p_full_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        window_full |=> window_full);

    // R6: the fill flag rises only on an accepted sample.
    p_full_on_valid_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(window_full) |-> $past(in_valid));

    // R7: the slot dropped by age matches the caller's outgoing sample.
    p_evict_match_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> dropped == evict_sample);

endmodule

// File: tb/sw_rank_sorter_test.sv
`timescale 1ns/1ps
module sw_rank_sorter_test;

    typedef logic [7:0] win_t [16];

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [7:0]   in_sample;
    logic [7:0]   evict_sample;
    logic [127:0] sorted_out;
    logic [7:0]   rank_out;
    logic         window_full;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;
    win_t arrivals;
    int   accepted;
    logic [7:0] prev_rank;

    always #2 clk = ~clk;

    sw_rank_sorter uut (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_sample    (in_sample),
        .evict_sample (evict_sample),
        .sorted_out   (sorted_out),
        .rank_out     (rank_out),
        .window_full  (window_full)
    );

    function automatic win_t sort_win(input win_t w);
        win_t s = w;
        for (int i = 1; i < 16; i++) begin
            logic [7:0] key = s[i];
            int j = i - 1;
            while (j >= 0 && s[j] > key) begin
                s[j+1] = s[j];
                j--;
            end
            s[j+1] = key;
        end
        return s;
    endfunction

    function automatic logic [127:0] pack_win(input win_t w);
        logic [127:0] p;
        for (int k = 0; k < 16; k++) p[k*8 +: 8] = w[k];
        return p;
    endfunction

    // Called at a falling edge.
    task automatic check_state(input bit was_valid);
        win_t         srt = sort_win(arrivals);
        logic [127:0] exp = pack_win(srt);
        bit           asc = 1;
        // R3 R8: slot k of the sorted window sits at bits [8k+7:8k]
        checks++;
        if (sorted_out !== exp) begin
            errors++;
            $display("FAIL %s sorted_out got %h exp %h",
                     was_valid ? "R3 R8" : "R5", sorted_out, exp);
        end
        // R2: output is nondecreasing
        for (int k = 0; k < 15; k++)
            if (sorted_out[k*8 +: 8] > sorted_out[(k+1)*8 +: 8]) asc = 0;
        checks++;
        if (!asc) begin
            errors++;
            $display("FAIL R2 order got %h exp nondecreasing", sorted_out);
        end
        // R4: the rank tap lags the window by one register
        checks++;
        if (rank_out !== prev_rank) begin
            errors++;
            $display("FAIL R4 rank_out got %0d exp %0d", rank_out, prev_rank);
        end
        prev_rank = srt[11];
        // R6: fill flag
        checks++;
        if (window_full !== (accepted >= 16)) begin
            errors++;
            $display("FAIL R6 window_full got %b exp %b",
                     window_full, (accepted >= 16));
        end
    endtask

    // Drive at a falling edge, then check at the next one.
    task automatic step(input bit v, input logic [7:0] x);
        in_valid     = v;
        in_sample    = x;
        evict_sample = arrivals[0];   // R7: the oldest queued value
        @(posedge clk);
        if (v) begin
            for (int i = 0; i < 15; i++) arrivals[i] = arrivals[i+1];
            arrivals[15] = x;
            accepted++;
        end
        @(negedge clk);
        check_state(v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        in_sample = '0;
        evict_sample = '0;
        for (int i = 0; i < 16; i++) arrivals[i] = '0;
        accepted  = 0;
        prev_rank = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        checks++;
        if (sorted_out !== '0 || rank_out !== '0 || window_full !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset got %h/%0d/%b exp 0/0/0",
                     sorted_out, rank_out, window_full);
        end

        // Ascending ramp crossing the fill boundary.
        for (int i = 0; i < 256; i++) step(1'b1, 8'(i));
        // Descending ramp.
        for (int i = 255; i >= 0; i--) step(1'b1, 8'(i));
        // Constant run, then idle cycles (R5).
        for (int i = 0; i < 40; i++) step(1'b1, 8'd77);
        for (int i = 0; i < 8; i++) step(1'b0, 8'd200);
        // Alternating extremes.
        for (int i = 0; i < 64; i++) step(1'b1, (i % 2 == 1) ? 8'd255 : 8'd0);
        // Heavy ties from a narrow range.
        for (int i = 0; i < 500; i++) step(1'b1, 8'($urandom_range(3, 0)));
        // Full-range values with idle gaps.
        for (int i = 0; i < 800; i++)
            step($urandom_range(9, 0) > 2, 8'($urandom_range(255, 0)));

        // Reset again mid-stream; R1 and the fill flag restart (R6).
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) arrivals[i] = '0;
        accepted  = 0;
        prev_rank = '0;
        checks++;
        if (sorted_out !== '0 || window_full !== 1'b0) begin
            errors++;
            $display("FAIL R1 re-reset got %h/%b exp 0/0", sorted_out, window_full);
        end
        for (int i = 0; i < 20; i++) step(1'b1, 8'(250 - i));

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule